// File: doc/BRIEF.md
# Address-Match Breakpoint Unit

This block watches a processor's 16-bit address bus and raises an active-high breakpoint signal whenever a qualified bus address equals a programmed breakpoint address. A small write-only register port loads the breakpoint address one byte at a time, and sets an enable bit and an output-shape bit. A sticky status output records that a match has happened since it was last cleared.

The output has two shapes. In level mode it follows the comparator, one clock after the address is presented. In pulse mode a match launches a pulse of exactly eight clocks. Matches that arrive while that pulse is high are ignored. Clearing the enable bit drops the output at once, in either mode.

The address is loaded high byte first. The high byte waits in a staging register and is applied together with the low byte, so the comparator never sees half of an old address and half of a new one.

Top module: `bkpt_watch`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `bkpt_o` and `hit_sticky_o` are 0. After reset the enable bit, the pulse-mode bit and the breakpoint address are all 0.
- R2: In level mode (control bit 1 = 0), `bkpt_o` is high in the cycle after a rising clock edge at which all of these hold: `addr_vld_i` is 1, `addr_i` equals the breakpoint address, and the enable bit is 1. In every other cycle it is low.
- R3: While the enable bit (control bit 0, written with `reg_sel_i` = 2) is 0, no address produces a match. `bkpt_o` stays low and `hit_sticky_o` is not set.
- R4: A control write with bit 0 = 0 makes `bkpt_o` low in the cycle after that write's clock edge, even if a match is present on the bus or a pulse is in progress. Any pulse in progress is abandoned.
- R5: In pulse mode (control bit 1 = 1), a qualified match seen while `bkpt_o` is low makes `bkpt_o` high for exactly 8 consecutive cycles, starting in the next cycle.
- R6: In pulse mode, a match seen while `bkpt_o` is high neither restarts nor extends the pulse. A match presented after the pulse has ended starts a new pulse.
- R7: `hit_sticky_o` becomes 1 in the cycle after any qualified match and then holds. It is cleared by writing `reg_sel_i` = 3 with bit 0 = 1. Writing bit 0 = 0 leaves it unchanged. If a match and a clear arrive in the same cycle, the match wins.
- R8: A write with `reg_sel_i` = 0 stores the high address byte in a staging register without changing the active breakpoint address. A write with `reg_sel_i` = 1 loads the active address as {staged high byte, written low byte}, and that address is used from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Processor address bus |
| addr_vld_i | input | 1 | Qualifies `addr_i` as a real bus access |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 high byte, 1 low byte, 2 control, 3 status clear |
| reg_wdata_i | input | 8 | Register write data |
| bkpt_o | output | 1 | Breakpoint signal, active high |
| hit_sticky_o | output | 1 | Sticky match status |

## Verification
Suppose the staging register leaked into the active address. A lone high-byte write would then make an address that should still match fail one cycle later, and an address that should not yet match would hit. Suppose instead the pulse counter reloaded or skipped a count. The high run on `bkpt_o` would come out at a length other than eight, and this shows within about ten cycles of the trigger. A lost clear of the pulse state on disable would show as `bkpt_o` still high in the cycle right after the control write, and a stale sticky flag is visible as soon as the status clear takes effect.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    typedef enum logic [1:0] {
        SEL_ADDR_HI = 2'd0,
        SEL_ADDR_LO = 2'd1,
        SEL_CTRL    = 2'd2,
        SEL_STAT    = 2'd3
    } reg_sel_e;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_PULSE_BIT = 1;
    localparam int STAT_HIT_BIT   = 0;

    typedef struct packed {
        logic pulse;
        logic en;
    } ctrl_t;

endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                we_i,
    input  logic [1:0]          sel_i,
    input  logic [ADDR_W/2-1:0] wdata_i,
    output logic [ADDR_W-1:0]   bp_addr_o,
    output ctrl_t               ctrl_o,
    output logic                kill_o,
    output logic                stat_clr_o
);
    localparam int HALF_W = ADDR_W / 2;

    typedef struct packed {
        logic [HALF_W-1:0] hi_stage;
        logic [ADDR_W-1:0] addr;
        ctrl_t             ctrl;
    } regs_t;

    regs_t    regs_d, regs_q;
    reg_sel_e sel;

    always_comb begin
        sel        = reg_sel_e'(sel_i);
        regs_d     = regs_q;
        kill_o     = 1'b0;
        stat_clr_o = 1'b0;
        if (we_i) begin
            unique case (sel)
                SEL_ADDR_HI: regs_d.hi_stage = wdata_i;
                SEL_ADDR_LO: regs_d.addr     = {regs_q.hi_stage, wdata_i};
                SEL_CTRL: begin
                    regs_d.ctrl.en    = wdata_i[CTRL_EN_BIT];
                    regs_d.ctrl.pulse = wdata_i[CTRL_PULSE_BIT];
                    kill_o            = ~wdata_i[CTRL_EN_BIT];
                end
                SEL_STAT:    stat_clr_o = wdata_i[STAT_HIT_BIT];
                default:     regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign bp_addr_o = regs_q.addr;
    assign ctrl_o    = regs_q.ctrl;

endmodule

// File: rtl/bkpt_cmp.sv
module bkpt_cmp #(
    parameter int ADDR_W = 16,
    parameter int LANE_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              addr_vld_i,
    input  logic [ADDR_W-1:0] bp_addr_i,
    input  logic              en_i,
    output logic              hit_o
);
    localparam int LANES = ADDR_W / LANE_W;

    logic [LANES-1:0] lane_eq;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_eq[g] = (addr_i[g*LANE_W +: LANE_W] == bp_addr_i[g*LANE_W +: LANE_W]);
    end

    always_comb begin
        hit_o = addr_vld_i & en_i & (&lane_eq);
    end

endmodule

// File: rtl/bkpt_shaper.sv
module bkpt_shaper #(
    parameter int PULSE_LEN = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hit_i,
    input  logic pulse_mode_i,
    input  logic kill_i,
    input  logic stat_clr_i,
    output logic bkpt_o,
    output logic sticky_o
);
    localparam int CNT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PULSE_LEN - 1);

    typedef struct packed {
        logic             out;
        logic [CNT_W-1:0] rem;
        logic             sticky;
    } shp_t;

    shp_t shp_d, shp_q;

    always_comb begin
        shp_d = shp_q;
        if (kill_i) begin
            shp_d.out = 1'b0;
            shp_d.rem = '0;
        end else if (!pulse_mode_i) begin
            shp_d.out = hit_i;
            shp_d.rem = '0;
        end else if (shp_q.out) begin
            if (shp_q.rem == '0) begin
                shp_d.out = 1'b0;
            end else begin
                shp_d.rem = shp_q.rem - 1'b1;
            end
        end else if (hit_i) begin
            shp_d.out = 1'b1;
            shp_d.rem = RELOAD;
        end

        if (hit_i) begin
            shp_d.sticky = 1'b1;
        end else if (stat_clr_i) begin
            shp_d.sticky = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            shp_q <= '0;
        end else begin
            shp_q <= shp_d;
        end
    end

    assign bkpt_o   = shp_q.out;
    assign sticky_o = shp_q.sticky;

endmodule

// File: rtl/bkpt_watch.sv
module bkpt_watch
    import bkpt_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int PULSE_LEN = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                addr_vld_i,
    input  logic                reg_we_i,
    input  logic [1:0]          reg_sel_i,
    input  logic [ADDR_W/2-1:0] reg_wdata_i,
    output logic                bkpt_o,
    output logic                hit_sticky_o
);
    localparam int HALF_W = ADDR_W / 2;

    logic [ADDR_W-1:0] bp_addr;
    ctrl_t             ctrl;
    logic              kill;
    logic              stat_clr;
    logic              hit;

    bkpt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .we_i       (reg_we_i),
        .sel_i      (reg_sel_i),
        .wdata_i    (reg_wdata_i),
        .bp_addr_o  (bp_addr),
        .ctrl_o     (ctrl),
        .kill_o     (kill),
        .stat_clr_o (stat_clr)
    );

    bkpt_cmp #(.ADDR_W(ADDR_W), .LANE_W(HALF_W)) u_cmp (
        .addr_i     (addr_i),
        .addr_vld_i (addr_vld_i),
        .bp_addr_i  (bp_addr),
        .en_i       (ctrl.en),
        .hit_o      (hit)
    );

    bkpt_shaper #(.PULSE_LEN(PULSE_LEN)) u_shaper (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .hit_i        (hit),
        .pulse_mode_i (ctrl.pulse),
        .kill_i       (kill),
        .stat_clr_i   (stat_clr),
        .bkpt_o       (bkpt_o),
        .sticky_o     (hit_sticky_o)
    );

endmodule

// File: rtl/bkpt_watch_chk.sv
module bkpt_watch_chk #(
    parameter int ADDR_W    = 16,
    parameter int PULSE_LEN = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              hit,
    input logic              ctrl_en,
    input logic              ctrl_pulse,
    input logic              kill,
    input logic              stat_clr,
    input logic              reg_we,
    input logic [1:0]        reg_sel,
    input logic [ADDR_W-1:0] bp_addr,
    input logic              bkpt_o,
    input logic              sticky_o
);
    localparam int RUN_W = $clog2(PULSE_LEN + 2) + 1;

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_q <= '0;
        end else if (bkpt_o && ctrl_pulse) begin
            if (run_q != '1) run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk_i) !rst_ni |=> (!bkpt_o && !sticky_o)); // R1
    AST_LEVEL_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ctrl_pulse && !kill) |=> (bkpt_o == $past(hit))); // R2
    AST_DISABLED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctrl_en |=> !bkpt_o); // R3
    AST_KILL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        kill |=> !bkpt_o); // R4
    AST_PULSE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_pulse && hit && !bkpt_o && !kill) |=> bkpt_o); // R5
    AST_PULSE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_q <= RUN_W'(PULSE_LEN)); // R6
    AST_STICKY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit |=> sticky_o); // R7
    AST_STICKY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_clr && !hit) |=> !sticky_o); // R7
    AST_STAGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_we && reg_sel == 2'd0) |=> $stable(bp_addr)); // R8

endmodule

bind bkpt_watch bkpt_watch_chk #(.ADDR_W(ADDR_W), .PULSE_LEN(PULSE_LEN)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit        (hit),
    .ctrl_en    (ctrl.en),
    .ctrl_pulse (ctrl.pulse),
    .kill       (kill),
    .stat_clr   (stat_clr),
    .reg_we     (reg_we_i),
    .reg_sel    (reg_sel_i),
    .bp_addr    (bp_addr),
    .bkpt_o     (bkpt_o),
    .sticky_o   (hit_sticky_o)
);

// File: tb/bkpt_watch_tb.sv
module bkpt_watch_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        vld = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  sel = '0;
    logic [7:0]  wdata = '0;
    logic        bkpt;
    logic        sticky;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    bkpt_watch u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .addr_i       (addr),
        .addr_vld_i   (vld),
        .reg_we_i     (we),
        .reg_sel_i    (sel),
        .reg_wdata_i  (wdata),
        .bkpt_o       (bkpt),
        .hit_sticky_o (sticky)
    );

    // {addr, vld, expected bkpt, expected sticky}; breakpoint A5C3, level mode, enabled
    localparam logic [18:0] VEC [8] = '{
        {16'hC3A5, 1'b1, 1'b0, 1'b0},
        {16'hA5C3, 1'b0, 1'b0, 1'b0},
        {16'hA5C3, 1'b1, 1'b1, 1'b1},
        {16'hA5C2, 1'b1, 1'b0, 1'b1},
        {16'h25C3, 1'b1, 1'b0, 1'b1},
        {16'hA5C3, 1'b1, 1'b1, 1'b1},
        {16'hA5C3, 1'b1, 1'b1, 1'b1},
        {16'h0000, 1'b1, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        we = 1'b1; sel = s; wdata = d;
        step();
        we = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int highs;
        repeat (3) @(negedge clk);
        chk("R1 bkpt in reset", int'(bkpt), 0);
        chk("R1 sticky in reset", int'(sticky), 0);
        rst_n = 1'b1;
        step();
        chk("R1 bkpt after reset", int'(bkpt), 0);

        // R8 program A5C3, then enable level mode (R2)
        wr(2'd0, 8'hA5);
        wr(2'd1, 8'hC3);
        wr(2'd2, 8'h01);
        for (int i = 0; i < 8; i++) begin
            addr = VEC[i][18:3];
            vld  = VEC[i][2];
            step();
            chk($sformatf("R2 vec%0d bkpt", i), int'(bkpt), int'(VEC[i][1]));
            chk($sformatf("R7 vec%0d sticky", i), int'(sticky), int'(VEC[i][0]));
        end
        addr = '0;

        // R7 clear, R3 disabled gate
        wr(2'd3, 8'h01);
        chk("R7 sticky cleared", int'(sticky), 0);
        wr(2'd2, 8'h00);
        addr = 16'hA5C3; vld = 1'b1;
        step();
        chk("R3 disabled bkpt", int'(bkpt), 0);
        step();
        chk("R3 disabled sticky", int'(sticky), 0);
        addr = '0;
        wr(2'd2, 8'h01);

        // R7 write-zero has no effect
        addr = 16'hA5C3;
        step();
        chk("R7 hit sets sticky", int'(sticky), 1);
        addr = '0;
        wr(2'd3, 8'h00);
        chk("R7 write 0 keeps sticky", int'(sticky), 1);
        wr(2'd3, 8'h01);
        chk("R7 write 1 clears sticky", int'(sticky), 0);

        // R8 staging of the high byte
        wr(2'd0, 8'h12);
        addr = 16'hA5C3;
        step();
        chk("R8 old address still active", int'(bkpt), 1);
        addr = 16'h12C3;
        step();
        chk("R8 staged byte not applied", int'(bkpt), 0);
        addr = '0;
        wr(2'd1, 8'h34);
        addr = 16'h1234;
        step();
        chk("R8 new address active", int'(bkpt), 1);
        addr = 16'hA5C3;
        step();
        chk("R8 old address gone", int'(bkpt), 0);

        // R4 level-mode disable with match held
        addr = 16'h1234;
        step();
        chk("R4 level match before disable", int'(bkpt), 1);
        wr(2'd2, 8'h00);
        chk("R4 level disable drops output", int'(bkpt), 0);
        addr = '0;

        // R5 pulse length
        wr(2'd2, 8'h03);
        addr = 16'h1234;
        step();
        chk("R5 pulse starts", int'(bkpt), 1);
        addr = '0;
        highs = 1;
        for (int i = 0; i < 11; i++) begin
            step();
            if (bkpt) highs++;
        end
        chk("R5 pulse length", highs, 8);
        chk("R5 pulse ended", int'(bkpt), 0);

        // R6 match during pulse ignored, fresh match retriggers
        addr = 16'h1234;
        step();
        addr = '0;
        highs = 1;
        for (int i = 0; i < 11; i++) begin
            addr = (i == 2) ? 16'h1234 : 16'h0000;
            step();
            if (bkpt) highs++;
        end
        addr = '0;
        chk("R6 pulse not extended", highs, 8);
        addr = 16'h1234;
        step();
        chk("R6 fresh match retriggers", int'(bkpt), 1);
        addr = '0;
        step();
        chk("R4 pulse running before disable", int'(bkpt), 1);

        // R4 abort pulse
        wr(2'd2, 8'h02);
        chk("R4 pulse aborted", int'(bkpt), 0);
        step();
        step();
        chk("R4 stays low after abort", int'(bkpt), 0);

        finish_run();
    end

endmodule